// File: doc/BRIEF.md
# Parallel Issue Group Resource Checker

This block examines one group of up to eight decoded instructions that a wide-issue processor intends to start in the same cycle. It reports whether the group breaks any static resource rule of the datapath. The datapath has two halves, A and B. Each half has four functional units: a logic unit, a shift unit, a multiply unit and a data/address unit. Each half also has its own sixteen-entry register file.

Every slot carries the following:
- a valid flag;
- the code of the unit it targets;
- a flag saying that one operand crosses over from the other half;
- an operation class;
- a destination register, two source registers and a two-bit mask saying which sources are read;
- for memory operations, the half that supplies the address register.

The checker evaluates six independent rules on the group and registers the result. A violation mask and a single legal flag appear one clock after the group is presented. An issue stage or an assembler-side model can use the flag to reject or split a group. The block decodes no instruction words and keeps no state between groups.

Top module: `vpc_packet_check`

## Requirements
- R1: Unit code is {half, kind}: half 0 is A and 1 is B; kind 0 is logic, 1 is shift, 2 is multiply, 3 is data/address. Two valid slots with the same unit code set mask bit 0.
- R2: Mask bit 1 is set when more than one valid slot on half A's logic, shift or multiply units has its cross flag set. The same holds for half B. Cross flags on data/address units are not counted.
- R3: A valid load (class 2) or store (class 3) on a data/address unit whose address-half input differs from the unit's half sets mask bit 2.
- R4: A register is {file, index} with file 0 meaning A. Mask bit 3 is set when a valid load writes a register in some file and a valid store takes its data (source 0) from a register in the same file.
- R5: Mask bit 4 is set when any one 5-bit register appears more than four times among the enabled sources of valid slots. Source enable bit 0 gates source 0 and bit 1 gates source 1.
- R6: Mask bit 5 is set when two valid non-store slots of the same class name the same destination. Equal class means equal write latency: arithmetic (class 0) takes 1 cycle, multiply (class 1) takes 2 and load takes 5. Same-destination writes of different classes are allowed.
- R7: Mask and legal flag are registered and reflect the group presented in the previous cycle. The legal flag is 1 exactly when the mask is zero. During reset the mask is 0 and the legal flag is 1.
- R8: Slots whose valid flag is 0 take part in no rule, whatever their other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 8 | Slot valid flags |
| in_unit | input | 8x3 | Target unit code per slot |
| in_op | input | 8x2 | Operation class: 0 arithmetic, 1 multiply, 2 load, 3 store |
| in_xpath | input | 8 | Operand taken over the cross path |
| in_addr_side | input | 8 | Half supplying the address register (memory ops) |
| in_dst | input | 8x5 | Destination register {file, index} |
| in_src0 | input | 8x5 | First source register (store data) |
| in_src1 | input | 8x5 | Second source register |
| in_src_en | input | 8x2 | Enables for source 0 (bit 0) and source 1 (bit 1) |
| pkt_legal | output | 1 | Group breaks no rule (registered) |
| viol_mask | output | 6 | Per-rule violation bits (registered) |

## Verification
All six rules are evaluated on the same group in the same cycle. The interesting coincidence is a unit clash together with a write clash: two same-class slots aimed at one unit and at one destination. It must raise both bits and not just one. Random groups are drawn with narrow register and unit ranges, so several rules fire together often. Each bit of the mask is judged separately against a bench model that counts unit occupancy and register reads with histograms rather than pairwise compares. Directed groups add the boundary of exactly four versus five reads, different-latency writes to one register, and conflicts hidden in invalid slots.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int UNIT_W = 3;
  localparam int OP_W   = 2;
  localparam int NRULE  = 6;

  localparam logic [OP_W-1:0] OP_ALU   = 2'd0;
  localparam logic [OP_W-1:0] OP_MUL   = 2'd1;
  localparam logic [OP_W-1:0] OP_LOAD  = 2'd2;
  localparam logic [OP_W-1:0] OP_STORE = 2'd3;

  localparam logic [1:0] KIND_DATA = 2'd3;

  localparam int MB_UNIT  = 0;
  localparam int MB_XPATH = 1;
  localparam int MB_ADDR  = 2;
  localparam int MB_LDST  = 3;
  localparam int MB_READ  = 4;
  localparam int MB_WRITE = 5;

  function automatic logic unit_half(input logic [UNIT_W-1:0] u);
    return u[UNIT_W-1];
  endfunction

  function automatic logic [1:0] unit_kind(input logic [UNIT_W-1:0] u);
    return u[1:0];
  endfunction

  function automatic logic is_mem(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

  function automatic logic writes_reg(input logic [OP_W-1:0] op);
    return op != OP_STORE;
  endfunction

  function automatic logic [2:0] write_latency(input logic [OP_W-1:0] op);
    case (op)
      OP_ALU:  return 3'd1;
      OP_MUL:  return 3'd2;
      OP_LOAD: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/vpc_pair_rules.sv
module vpc_pair_rules
  import vpc_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int REG_W = 5
) (
  input  logic [NSLOT-1:0]             valid,
  input  logic [NSLOT-1:0][UNIT_W-1:0] unit,
  input  logic [NSLOT-1:0][OP_W-1:0]   op,
  input  logic [NSLOT-1:0][REG_W-1:0]  dst,
  output logic                         unit_clash,
  output logic                         write_clash
);
  always_comb begin
    unit_clash  = 1'b0;
    write_clash = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      for (int j = i + 1; j < NSLOT; j++) begin
        if (valid[i] && valid[j]) begin
          if (unit[i] == unit[j]) unit_clash = 1'b1;
          if (writes_reg(op[i]) && writes_reg(op[j]) &&
              (write_latency(op[i]) == write_latency(op[j])) &&
              (dst[i] == dst[j]))
            write_clash = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vpc_side_rules.sv
module vpc_side_rules
  import vpc_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int REG_W = 5
) (
  input  logic [NSLOT-1:0]             valid,
  input  logic [NSLOT-1:0][UNIT_W-1:0] unit,
  input  logic [NSLOT-1:0][OP_W-1:0]   op,
  input  logic [NSLOT-1:0]             xpath,
  input  logic [NSLOT-1:0]             addr_side,
  input  logic [NSLOT-1:0][REG_W-1:0]  dst,
  input  logic [NSLOT-1:0][REG_W-1:0]  src0,
  output logic                         xpath_over,
  output logic                         addr_bad,
  output logic                         ldst_clash
);
  localparam int CW = $clog2(NSLOT + 1);

  logic [1:0][CW-1:0] xp_cnt;
  logic [1:0]         load_file;
  logic [1:0]         store_file;

  always_comb begin
    xp_cnt     = '0;
    addr_bad   = 1'b0;
    load_file  = '0;
    store_file = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (valid[i]) begin
        if (xpath[i] && (unit_kind(unit[i]) != KIND_DATA))
          xp_cnt[unit_half(unit[i])] = xp_cnt[unit_half(unit[i])] + 1'b1;
        if (is_mem(op[i]) && (unit_kind(unit[i]) == KIND_DATA) &&
            (addr_side[i] != unit_half(unit[i])))
          addr_bad = 1'b1;
        if (op[i] == OP_LOAD)  load_file[dst[i][REG_W-1]]   = 1'b1;
        if (op[i] == OP_STORE) store_file[src0[i][REG_W-1]] = 1'b1;
      end
    end
  end

  assign xpath_over = (xp_cnt[0] > CW'(1)) || (xp_cnt[1] > CW'(1));
  assign ldst_clash = |(load_file & store_file);
endmodule

// File: rtl/vpc_read_count.sv
module vpc_read_count #(
  parameter int NSLOT    = 8,
  parameter int REG_W    = 5,
  parameter int READ_CAP = 4
) (
  input  logic [NSLOT-1:0]            valid,
  input  logic [NSLOT-1:0][1:0]       src_en,
  input  logic [NSLOT-1:0][REG_W-1:0] src0,
  input  logic [NSLOT-1:0][REG_W-1:0] src1,
  output logic                        read_over
);
  localparam int NSRC = 2 * NSLOT;
  localparam int CW   = $clog2(NSRC + 1);

  logic [NSRC-1:0]            rd_used;
  logic [NSRC-1:0][REG_W-1:0] rd_reg;
  logic [NSRC-1:0]            rd_over;

  for (genvar s = 0; s < NSLOT; s++) begin : g_flat
    assign rd_used[2*s]   = valid[s] & src_en[s][0];
    assign rd_used[2*s+1] = valid[s] & src_en[s][1];
    assign rd_reg[2*s]    = src0[s];
    assign rd_reg[2*s+1]  = src1[s];
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_cnt
    logic [CW-1:0] hits;
    always_comb begin
      hits = '0;
      for (int j = 0; j < NSRC; j++)
        if (rd_used[j] && (rd_reg[j] == rd_reg[k])) hits = hits + 1'b1;
    end
    assign rd_over[k] = rd_used[k] && (hits > CW'(READ_CAP));
  end

  assign read_over = |rd_over;
endmodule

// File: rtl/vpc_packet_check.sv
module vpc_packet_check
  import vpc_pkg::*;
#(
  parameter int NSLOT    = 8,
  parameter int RIDX_W   = 4,
  parameter int READ_CAP = 4,
  localparam int REG_W   = RIDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSLOT-1:0]             in_valid,
  input  logic [NSLOT-1:0][UNIT_W-1:0] in_unit,
  input  logic [NSLOT-1:0][OP_W-1:0]   in_op,
  input  logic [NSLOT-1:0]             in_xpath,
  input  logic [NSLOT-1:0]             in_addr_side,
  input  logic [NSLOT-1:0][REG_W-1:0]  in_dst,
  input  logic [NSLOT-1:0][REG_W-1:0]  in_src0,
  input  logic [NSLOT-1:0][REG_W-1:0]  in_src1,
  input  logic [NSLOT-1:0][1:0]        in_src_en,
  output logic                         pkt_legal,
  output logic [NRULE-1:0]             viol_mask
);
  logic unit_clash, write_clash, xpath_over, addr_bad, ldst_clash, read_over;
  logic [NRULE-1:0] viol_next;

  vpc_pair_rules #(.NSLOT(NSLOT), .REG_W(REG_W)) u_pair (
    .valid(in_valid), .unit(in_unit), .op(in_op), .dst(in_dst),
    .unit_clash(unit_clash), .write_clash(write_clash)
  );

  vpc_side_rules #(.NSLOT(NSLOT), .REG_W(REG_W)) u_side (
    .valid(in_valid), .unit(in_unit), .op(in_op), .xpath(in_xpath),
    .addr_side(in_addr_side), .dst(in_dst), .src0(in_src0),
    .xpath_over(xpath_over), .addr_bad(addr_bad), .ldst_clash(ldst_clash)
  );

  vpc_read_count #(.NSLOT(NSLOT), .REG_W(REG_W), .READ_CAP(READ_CAP)) u_read (
    .valid(in_valid), .src_en(in_src_en), .src0(in_src0), .src1(in_src1),
    .read_over(read_over)
  );

  always_comb begin
    viol_next           = '0;
    viol_next[MB_UNIT]  = unit_clash;
    viol_next[MB_XPATH] = xpath_over;
    viol_next[MB_ADDR]  = addr_bad;
    viol_next[MB_LDST]  = ldst_clash;
    viol_next[MB_READ]  = read_over;
    viol_next[MB_WRITE] = write_clash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_mask <= '0;
      pkt_legal <= 1'b1;
    end else begin
      viol_mask <= viol_next;
      pkt_legal <= ~|viol_next;
    end
  end
endmodule

// File: rtl/vpc_packet_check_sva.sv
module vpc_packet_check_sva
  import vpc_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NSLOT-1:0]           in_valid,
  input logic [NSLOT-1:0][OP_W-1:0] in_op,
  input logic [NSLOT-1:0]           in_xpath,
  input logic                       pkt_legal,
  input logic [NRULE-1:0]           viol_mask,
  input logic [NRULE-1:0]           viol_next
);
  logic any_mem;
  always_comb begin
    any_mem = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      if (in_valid[i] && is_mem(in_op[i])) any_mem = 1'b1;
  end

  a_r7_legal_is_nor: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_legal == ~|viol_mask);

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> viol_mask == $past(viol_next));

  a_r8_empty_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |=> (pkt_legal && viol_mask == '0));

  a_r1_r6_lone_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_valid) <= 1) |=>
      (!viol_mask[MB_UNIT] && !viol_mask[MB_WRITE] && !viol_mask[MB_XPATH]));

  a_r2_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xpath == '0) |=> !viol_mask[MB_XPATH]);

  a_r3_r4_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    !any_mem |=> (!viol_mask[MB_ADDR] && !viol_mask[MB_LDST]));
endmodule

bind vpc_packet_check vpc_packet_check_sva #(.NSLOT(NSLOT)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_xpath(in_xpath), .pkt_legal(pkt_legal), .viol_mask(viol_mask),
  .viol_next(viol_next)
);

// File: tb/vpc_packet_check_bench.sv
`timescale 1ns/1ps
module vpc_packet_check_bench;
  localparam int NSLOT = 8;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NSLOT-1:0]      in_valid = '0;
  logic [NSLOT-1:0][2:0] in_unit = '0;
  logic [NSLOT-1:0][1:0] in_op = '0;
  logic [NSLOT-1:0]      in_xpath = '0;
  logic [NSLOT-1:0]      in_addr_side = '0;
  logic [NSLOT-1:0][4:0] in_dst = '0;
  logic [NSLOT-1:0][4:0] in_src0 = '0;
  logic [NSLOT-1:0][4:0] in_src1 = '0;
  logic [NSLOT-1:0][1:0] in_src_en = '0;
  logic                  pkt_legal;
  logic [5:0]            viol_mask;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vpc_packet_check u_vpc_packet_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_op(in_op), .in_xpath(in_xpath), .in_addr_side(in_addr_side),
    .in_dst(in_dst), .in_src0(in_src0), .in_src1(in_src1),
    .in_src_en(in_src_en), .pkt_legal(pkt_legal), .viol_mask(viol_mask)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bench model: histograms over units and registers
  function automatic logic [5:0] model();
    logic [5:0] m = '0;
    int occ[8];
    int xc[2];
    int rc[32];
    bit ld[2];
    bit st[2];
    foreach (occ[u]) occ[u] = 0;
    foreach (rc[r]) rc[r] = 0;
    xc[0] = 0; xc[1] = 0; ld[0] = 0; ld[1] = 0; st[0] = 0; st[1] = 0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!in_valid[i]) continue;
      occ[in_unit[i]]++;
      if (in_xpath[i] && in_unit[i][1:0] != 2'd3) xc[in_unit[i][2]]++;
      if (in_op[i] >= 2 && in_unit[i][1:0] == 2'd3 && in_addr_side[i] != in_unit[i][2])
        m[2] = 1'b1;
      if (in_op[i] == 2) ld[in_dst[i][4]] = 1;
      if (in_op[i] == 3) st[in_src0[i][4]] = 1;
      if (in_src_en[i][0]) rc[in_src0[i]]++;
      if (in_src_en[i][1]) rc[in_src1[i]]++;
      for (int j = i + 1; j < NSLOT; j++)
        if (in_valid[j] && in_op[i] != 3 && in_op[i] == in_op[j] && in_dst[i] == in_dst[j])
          m[5] = 1'b1;
    end
    foreach (occ[u]) if (occ[u] > 1) m[0] = 1'b1;
    if (xc[0] > 1 || xc[1] > 1) m[1] = 1'b1;
    if ((ld[0] && st[0]) || (ld[1] && st[1])) m[3] = 1'b1;
    foreach (rc[r]) if (rc[r] > 4) m[4] = 1'b1;
    return m;
  endfunction

  // called just after a negedge with the group already driven
  task automatic run_pkt(input string tag);
    logic [5:0] e;
    string names[6];
    names = '{"R1 unit", "R2 cross", "R3 addr", "R4 ldst", "R5 read", "R6 write"};
    e = model();
    @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < 6; b++)
      chk(viol_mask[b] == e[b], {tag, " ", names[b]}, viol_mask[b], e[b]);
    chk(pkt_legal == (e == 6'd0), {tag, " R7 legal"}, pkt_legal, (e == 6'd0));
  endtask

  task automatic clear_pkt();
    in_valid = '0; in_unit = '0; in_op = '0; in_xpath = '0; in_addr_side = '0;
    in_dst = '0; in_src0 = '0; in_src1 = '0; in_src_en = '0;
  endtask

  task automatic put(input int s, input int u, input int op, input bit xp, input bit as,
                     input int d, input int a, input int b, input int en);
    in_valid[s] = 1'b1; in_unit[s] = 3'(u); in_op[s] = 2'(op); in_xpath[s] = xp;
    in_addr_side[s] = as; in_dst[s] = 5'(d); in_src0[s] = 5'(a); in_src1[s] = 5'(b);
    in_src_en[s] = 2'(en);
  endtask

  task automatic expect_mask(input string tag, input logic [5:0] want);
    logic [5:0] e;
    e = model();
    chk(e == want, {tag, " model"}, e, want);
    run_pkt(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog R7: got %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (2) @(negedge clk);
    chk(viol_mask == 6'd0, "R7 reset mask", viol_mask, 0);
    chk(pkt_legal == 1'b1, "R7 reset legal", pkt_legal, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // registers: A n = n, B n = 16+n ; units: L1 0,S1 1,M1 2,D1 3,L2 4,S2 5,M2 6,D2 7
    clear_pkt(); put(0, 0, 0, 0, 0, 2, 0, 1, 3); put(1, 4, 0, 0, 0, 18, 16, 17, 3);
    expect_mask("two adds R1", 6'b000000);
    clear_pkt(); put(0, 0, 0, 1, 0, 2, 0, 17, 3); put(1, 2, 1, 1, 0, 3, 5, 16, 3);
    expect_mask("two cross R2", 6'b000010);
    clear_pkt(); put(0, 0, 0, 1, 0, 2, 0, 17, 3); put(1, 3, 0, 1, 0, 3, 5, 16, 3);
    expect_mask("cross on data unit R2", 6'b000000);
    clear_pkt(); put(0, 7, 2, 0, 1, 1, 16, 0, 1);
    expect_mask("load D2 addr B R3", 6'b000000);
    clear_pkt(); put(0, 3, 2, 0, 1, 1, 16, 0, 1);
    expect_mask("load D1 addr B R3", 6'b000100);
    clear_pkt(); put(0, 3, 2, 0, 0, 1, 0, 0, 1); put(1, 7, 3, 0, 1, 0, 2, 16, 3);
    expect_mask("load A store A R4", 6'b001000);
    clear_pkt(); put(0, 3, 2, 0, 0, 17, 0, 0, 1); put(1, 7, 3, 0, 1, 0, 2, 16, 3);
    expect_mask("load B store A R4", 6'b000000);
    clear_pkt(); put(0, 0, 0, 0, 0, 2, 1, 1, 3); put(1, 2, 1, 0, 0, 3, 1, 1, 3);
    put(2, 3, 0, 0, 0, 5, 1, 4, 3);
    expect_mask("five reads R5", 6'b010000);
    in_src_en[2] = 2'b10;
    expect_mask("four reads R5", 6'b000000);
    clear_pkt(); put(0, 0, 0, 0, 0, 2, 1, 1, 3); put(1, 2, 1, 0, 0, 2, 1, 1, 3);
    expect_mask("mixed latency R6", 6'b000000);
    clear_pkt(); put(0, 0, 0, 0, 0, 2, 1, 3, 3); put(1, 1, 0, 0, 0, 2, 4, 5, 3);
    expect_mask("same latency R6", 6'b100000);
    clear_pkt(); put(0, 0, 0, 0, 0, 2, 1, 3, 3); put(1, 0, 0, 0, 0, 2, 4, 5, 3);
    expect_mask("unit and write R1 R6", 6'b100001);
    clear_pkt(); put(0, 0, 0, 1, 0, 2, 1, 1, 3); put(1, 0, 0, 1, 0, 2, 1, 1, 3);
    put(2, 3, 2, 1, 1, 1, 1, 1, 3); put(3, 7, 3, 0, 1, 0, 1, 16, 3);
    in_valid = 4'b0001;
    expect_mask("hidden slots R8", 6'b000000);

    for (int it = 0; it < 400; it++) begin
      for (int s = 0; s < NSLOT; s++) begin
        in_valid[s]     = ($urandom % 3) != 0;
        in_unit[s]      = 3'($urandom % 8);
        in_op[s]        = 2'($urandom % 4);
        in_xpath[s]     = ($urandom % 4) == 0;
        in_addr_side[s] = 1'($urandom % 2);
        in_dst[s]       = {1'($urandom % 2), 4'($urandom % 4)};
        in_src0[s]      = {1'($urandom % 2), 4'($urandom % 3)};
        in_src1[s]      = {1'($urandom % 2), 4'($urandom % 3)};
        in_src_en[s]    = 2'($urandom % 4);
      end
      if (it % 4 == 0) in_valid = NSLOT'($urandom % 4);
      run_pkt("random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule